// File: doc/BRIEF.md
# Serial Boot Session Sequencer

This block runs the later part of a serial boot-load session, after the opening handshake bytes have been exchanged. It takes bytes and a receive-error flag from a UART receiver. It drives a byte transmitter through a valid/ready handshake and learns from a `tx_done` pulse when a byte has fully left the line. It also drives the rate select of the serial link.

The first byte it handles is a rate code. A code that is legal for the configured clock frequency is echoed, and the new rate takes effect only once the echo has finished. Control then passes to an external hex record receiver. When that receiver reports an end record, the block sends the 16-bit memory sum, high byte first. It then expects a start command. A correct command is echoed and followed by a launch pulse that carries the entry address and the initial stack value.

Each phase fails in its own way. A bad rate code sends one error byte and stops. A loading error stops with nothing sent. A bad start command sends the error byte three times and then stops. Once stopped, the block stays stopped until reset.

Top module: `bootseq_ctrl`

## Requirements
- R1: After reset, `tx_valid`, `launch`, `hex_start` and `halted` are low and `baud_sel` is 0 (9600 bps).
- R2: The rate codes and their `baud_sel` indices are 28H→0, 18H→1, 0CH→2, 06H→3 and 03H→4. The code with index k is legal when k + `freq_sel` < 5. When a legal code arrives without `rx_err`, it is echoed on `tx_data`, and `baud_sel` takes the new index only on the clock edge where `tx_done` ends that echo.
- R3: If the rate byte is not legal for `freq_sel`, or arrives with `rx_err`, exactly one 62H is sent, `halted` then goes high and `baud_sel` keeps its old value.
- R4: One cycle after the echo's `tx_done`, `hex_start` is high for exactly one cycle. While the block waits for `hex_end` or `hex_err`, received bytes cause no transmission.
- R5: `hex_err` during loading sets `halted` and causes no transmission.
- R6: `hex_end` captures `mem_sum` and `hex_entry`. The sum is then sent high byte first and low byte second.
- R7: After the sum, the byte C0H received without `rx_err` is echoed. The cycle after that echo's `tx_done`, `launch` is high for one cycle, with `launch_pc` equal to the captured entry address and `launch_sp` equal to 4A000H.
- R8: Any other start byte, or a start byte with `rx_err`, sends 62H three times and then sets `halted`, with no launch.
- R9: `halted` is sticky until reset. While it is high, no byte is offered and `launch` stays low, whatever the inputs do.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_sel | input | 2 | Operating-frequency class; limits the legal rate codes |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive error on this byte |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| tx_done | input | 1 | Pulse: the accepted byte has fully left the line |
| baud_sel | output | 3 | Selected rate index |
| hex_start | output | 1 | Pulse: record receiver may begin |
| hex_end | input | 1 | Pulse: end record received cleanly |
| hex_err | input | 1 | Pulse: receive or checksum error while loading |
| hex_entry | input | 24 | First address seen in the record data |
| mem_sum | input | 16 | Memory sum from the loader |
| launch | output | 1 | Pulse: start the loaded program |
| launch_pc | output | 24 | Entry address for the launch |
| launch_sp | output | 24 | Initial stack value for the launch |
| halted | output | 1 | Session stopped until reset |

## Verification
The hardest case to reach is the threefold error on the start command, because it needs a full session first: a legal rate byte and its echo, a completed load, and both sum bytes. The bench's serializer model holds `tx_ready` low for a while and delays `tx_done`, so every one of these bytes passes through the hold and completion paths. The rate table is walked from a vector list that pairs each frequency class with codes just inside and just outside its legal set. Directed sessions then drive the load error, the wrong command and a command with a receive error. They also poke a halted block with the inputs that would otherwise send or launch.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;
  localparam int NUM_RATES = 5;
  localparam int RATE_IDX_W = 3;
  localparam int FSEL_W = 2;

  typedef enum logic [3:0] {
    S_BAUD, S_BAUD_ECHO, S_BAUD_ERR, S_HEXGO, S_HEX,
    S_SUM_HI, S_SUM_LO, S_CMD, S_CMD_ECHO, S_CMD_ERR,
    S_LAUNCH, S_RUN, S_HALT
  } sess_state_e;

  typedef enum logic [1:0] { T_IDLE, T_OFFER, T_FLIGHT } tx_state_e;

  function automatic logic [7:0] rate_code(input int k);
    case (k)
      0: rate_code = 8'h28;
      1: rate_code = 8'h18;
      2: rate_code = 8'h0C;
      3: rate_code = 8'h06;
      4: rate_code = 8'h03;
      default: rate_code = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bootseq_rate_lut.sv
module bootseq_rate_lut
  import bootseq_pkg::*;
(
  input  logic [7:0]            code,
  input  logic [FSEL_W-1:0]     fsel,
  output logic                  legal,
  output logic [RATE_IDX_W-1:0] idx
);
  localparam int SUM_W = RATE_IDX_W + 1;
  logic [NUM_RATES-1:0] hit;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    assign hit[g] = (code == rate_code(g)) &&
                    ((SUM_W'(g) + SUM_W'(fsel)) < SUM_W'(NUM_RATES));
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_RATES; k++) begin
      if (hit[k]) idx = RATE_IDX_W'(k);
    end
  end

  assign legal = |hit;
endmodule

// File: rtl/bootseq_txq.sv
module bootseq_txq
  import bootseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_en,
  input  logic [7:0] send_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       tx_done,
  output logic       sent
);
  tx_state_e st_q, st_d;
  logic [7:0] byte_q;
  logic       byte_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      T_IDLE:   if (send_en)  st_d = T_OFFER;
      T_OFFER:  if (tx_ready) st_d = T_FLIGHT;
      T_FLIGHT: if (tx_done)  st_d = T_IDLE;
      default:  st_d = T_IDLE;
    endcase
  end

  assign byte_en = (st_q == T_IDLE) && send_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      byte_q <= '0;
    end else begin
      st_q <= st_d;
      if (byte_en) byte_q <= send_byte;
    end
  end

  assign tx_valid = (st_q == T_OFFER);
  assign tx_data  = byte_q;
  assign sent     = (st_q == T_FLIGHT) && tx_done;
endmodule

// File: rtl/bootseq_ctrl.sv
module bootseq_ctrl
  import bootseq_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          SUM_W     = 16,
  parameter logic [7:0]  CMD_START = 8'hC0,
  parameter logic [7:0]  ERR_CODE  = 8'h62,
  parameter int          ERR_REPS  = 3,
  parameter logic [23:0] SP_INIT   = 24'h04A000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FSEL_W-1:0]     freq_sel,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_data,
  input  logic                  rx_err,
  output logic                  tx_valid,
  output logic [7:0]            tx_data,
  input  logic                  tx_ready,
  input  logic                  tx_done,
  output logic [RATE_IDX_W-1:0] baud_sel,
  output logic                  hex_start,
  input  logic                  hex_end,
  input  logic                  hex_err,
  input  logic [ADDR_W-1:0]     hex_entry,
  input  logic [SUM_W-1:0]      mem_sum,
  output logic                  launch,
  output logic [ADDR_W-1:0]     launch_pc,
  output logic [ADDR_W-1:0]     launch_sp,
  output logic                  halted
);
  localparam int CNT_W = $clog2(ERR_REPS + 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_s2_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  sess_state_e           st_q, st_d;
  logic [RATE_IDX_W-1:0] baud_q, pend_q, lut_idx;
  logic [7:0]            echo_q, send_byte;
  logic [ADDR_W-1:0]     pc_q;
  logic [SUM_W-1:0]      sum_q;
  logic [CNT_W-1:0]      errcnt_q, errcnt_d;
  logic                  lut_legal, send_en, sent;
  logic                  rate_ok, cmd_ok;
  logic                  baud_cap_en, baud_apply_en, load_cap_en, errcnt_en;

  bootseq_rate_lut u_lut (
    .code  (rx_data),
    .fsel  (freq_sel),
    .legal (lut_legal),
    .idx   (lut_idx)
  );

  assign rate_ok = rx_valid && !rx_err && lut_legal;
  assign cmd_ok  = rx_valid && !rx_err && (rx_data == CMD_START);

  always_comb begin
    st_d     = st_q;
    errcnt_d = errcnt_q;
    case (st_q)
      S_BAUD:      if (rx_valid) st_d = rate_ok ? S_BAUD_ECHO : S_BAUD_ERR;
      S_BAUD_ECHO: if (sent) st_d = S_HEXGO;
      S_BAUD_ERR:  if (sent) st_d = S_HALT;
      S_HEXGO:     st_d = S_HEX;
      S_HEX: begin
        if (hex_err)      st_d = S_HALT;
        else if (hex_end) st_d = S_SUM_HI;
      end
      S_SUM_HI:    if (sent) st_d = S_SUM_LO;
      S_SUM_LO:    if (sent) st_d = S_CMD;
      S_CMD:       if (rx_valid) st_d = cmd_ok ? S_CMD_ECHO : S_CMD_ERR;
      S_CMD_ECHO:  if (sent) st_d = S_LAUNCH;
      S_CMD_ERR: begin
        if (sent) begin
          errcnt_d = errcnt_q + 1'b1;
          if (errcnt_q == CNT_W'(ERR_REPS - 1)) st_d = S_HALT;
        end
      end
      S_LAUNCH:    st_d = S_RUN;
      S_RUN:       st_d = S_RUN;
      default:     st_d = S_HALT;
    endcase
  end

  always_comb begin
    send_en   = 1'b1;
    send_byte = ERR_CODE;
    case (st_q)
      S_BAUD_ECHO: send_byte = echo_q;
      S_SUM_HI:    send_byte = sum_q[SUM_W-1 -: 8];
      S_SUM_LO:    send_byte = sum_q[7:0];
      S_CMD_ECHO:  send_byte = CMD_START;
      S_BAUD_ERR, S_CMD_ERR: send_byte = ERR_CODE;
      default:     send_en = 1'b0;
    endcase
  end

  assign baud_cap_en   = (st_q == S_BAUD) && rate_ok;
  assign baud_apply_en = (st_q == S_BAUD_ECHO) && sent;
  assign load_cap_en   = (st_q == S_HEX) && hex_end && !hex_err;
  assign errcnt_en     = (st_q == S_CMD_ERR) && sent;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= S_BAUD;
      baud_q   <= '0;
      pend_q   <= '0;
      echo_q   <= '0;
      pc_q     <= '0;
      sum_q    <= '0;
      errcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (baud_cap_en) begin
        pend_q <= lut_idx;
        echo_q <= rx_data;
      end
      if (baud_apply_en) baud_q <= pend_q;
      if (load_cap_en) begin
        pc_q  <= hex_entry;
        sum_q <= mem_sum;
      end
      if (errcnt_en) errcnt_q <= errcnt_d;
    end
  end

  bootseq_txq u_txq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .send_en   (send_en),
    .send_byte (send_byte),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .tx_done   (tx_done),
    .sent      (sent)
  );

  assign baud_sel  = baud_q;
  assign hex_start = (st_q == S_HEXGO);
  assign launch    = (st_q == S_LAUNCH);
  assign launch_pc = pc_q;
  assign launch_sp = ADDR_W'(SP_INIT);
  assign halted    = (st_q == S_HALT);
endmodule

// File: rtl/bootseq_ctrl_chk.sv
module bootseq_ctrl_chk #(
  parameter int          ADDR_W  = 24,
  parameter logic [23:0] SP_INIT = 24'h04A000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_ready,
  input logic              tx_done,
  input logic [2:0]        baud_sel,
  input logic              hex_start,
  input logic              launch,
  input logic [ADDR_W-1:0] launch_sp,
  input logic              halted
);
  AST_RATE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(baud_sel) |-> $past(tx_done)); // R2
  AST_HEXSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hex_start |=> !hex_start); // R4
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch); // R7
  AST_LAUNCH_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> launch_sp == ADDR_W'(SP_INIT)); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !tx_valid && !launch); // R9
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10
endmodule

bind bootseq_ctrl bootseq_ctrl_chk #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .tx_ready  (tx_ready),
  .tx_done   (tx_done),
  .baud_sel  (baud_sel),
  .hex_start (hex_start),
  .launch    (launch),
  .launch_sp (launch_sp),
  .halted    (halted)
);

// File: tb/bootseq_ctrl_tb.sv
module bootseq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  freq_sel;
  logic        rx_valid, rx_err, tx_ready, tx_done, hex_end, hex_err;
  logic [7:0]  rx_data;
  logic [23:0] hex_entry;
  logic [15:0] mem_sum;
  logic        tx_valid, hex_start, launch, halted;
  logic [7:0]  tx_data;
  logic [2:0]  baud_sel;
  logic [23:0] launch_pc, launch_sp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bootseq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done),
    .baud_sel(baud_sel), .hex_start(hex_start), .hex_end(hex_end), .hex_err(hex_err),
    .hex_entry(hex_entry), .mem_sum(mem_sum), .launch(launch),
    .launch_pc(launch_pc), .launch_sp(launch_sp), .halted(halted)
  );

  // rows: {freq_sel[1:0], code[7:0], legal, index[2:0]}
  localparam logic [13:0] RATE_VEC [0:7] = '{
    {2'd0, 8'h28, 1'b1, 3'd0},
    {2'd0, 8'h03, 1'b1, 3'd4},
    {2'd1, 8'h03, 1'b0, 3'd0},
    {2'd1, 8'h06, 1'b1, 3'd3},
    {2'd3, 8'h0C, 1'b0, 3'd0},
    {2'd3, 8'h18, 1'b1, 3'd1},
    {2'd2, 8'h0C, 1'b1, 3'd2},
    {2'd0, 8'h55, 1'b0, 3'd0}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; freq_sel = 2'd0; rx_valid = 1'b0; rx_err = 1'b0; rx_data = 8'h00;
    tx_ready = 1'b0; tx_done = 1'b0; hex_end = 1'b0; hex_err = 1'b0;
    hex_entry = 24'h0; mem_sum = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic e);
    rx_valid = 1'b1; rx_data = d; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  // serializer model: waits for an offer, stalls ready, then completes
  task automatic expect_tx(input logic [7:0] exp, input string tag, input int pre_baud);
    int n = 0;
    while (!tx_valid && n < 60) begin @(negedge clk); n++; end
    chk(tx_valid == 1'b1, {tag, " offer"}, tx_valid, 1);
    chk(tx_data == exp, {tag, " byte"}, tx_data, exp);
    repeat (2) @(negedge clk);
    chk(tx_valid && tx_data == exp, "R10 held offer", tx_data, exp);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    repeat (2) @(negedge clk);
    if (pre_baud >= 0) chk(baud_sel == 3'(pre_baud), "R2 rate before done", baud_sel, pre_baud);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic expect_quiet(input int cyc, input string tag);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (tx_valid || launch) seen = 1;
      @(negedge clk);
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic good_rate_and_load(input logic [23:0] entry, input logic [15:0] sum);
    rx_byte(8'h28, 1'b0);
    expect_tx(8'h28, "R2 echo", 0);
    repeat (2) @(negedge clk);
    hex_entry = entry; mem_sum = sum; hex_end = 1'b1;
    @(negedge clk);
    hex_end = 1'b0; hex_entry = 24'h0; mem_sum = 16'h0;
    expect_tx(sum[15:8], "R6 sum high", -1);
    expect_tx(sum[7:0], "R6 sum low", -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(!tx_valid && !launch && !hex_start && !halted, "R1 reset outputs",
        {tx_valid, launch, hex_start, halted}, 0);
    chk(baud_sel == 3'd0, "R1 reset rate", baud_sel, 0);

    // R2/R3 rate table walk
    for (int v = 0; v < 8; v++) begin
      do_reset();
      freq_sel = RATE_VEC[v][13:12];
      rx_byte(RATE_VEC[v][11:4], 1'b0);
      if (RATE_VEC[v][3]) begin
        expect_tx(RATE_VEC[v][11:4], "R2 echo", 0);
        chk(baud_sel == RATE_VEC[v][2:0], "R2 new rate", baud_sel, RATE_VEC[v][2:0]);
        chk(hex_start == 1'b1, "R4 hex_start", hex_start, 1);
        @(negedge clk);
        chk(hex_start == 1'b0, "R4 hex_start one cycle", hex_start, 0);
      end else begin
        expect_tx(8'h62, "R3 rate error code", 0);
        chk(halted == 1'b1, "R3 halted", halted, 1);
        chk(baud_sel == 3'd0, "R3 rate kept", baud_sel, 0);
        expect_quiet(20, "R3 single error byte");
      end
    end

    // R3 receive error on the rate byte
    do_reset();
    rx_byte(8'h28, 1'b1);
    expect_tx(8'h62, "R3 rx_err code", 0);
    chk(halted == 1'b1, "R3 rx_err halted", halted, 1);

    // full session: R4 ignore, R6 sum, R7 launch
    do_reset();
    rx_byte(8'h28, 1'b0);
    expect_tx(8'h28, "R2 echo", 0);
    @(negedge clk);
    rx_byte(8'h3A, 1'b0);
    rx_byte(8'hC0, 1'b0);
    expect_quiet(10, "R4 rx ignored while loading");
    hex_entry = 24'h012340; mem_sum = 16'hBEEF; hex_end = 1'b1;
    @(negedge clk);
    hex_end = 1'b0; hex_entry = 24'h0; mem_sum = 16'h0;
    expect_tx(8'hBE, "R6 sum high", -1);
    expect_tx(8'hEF, "R6 sum low", -1);
    rx_byte(8'hC0, 1'b0);
    expect_tx(8'hC0, "R7 start echo", -1);
    chk(launch == 1'b1, "R7 launch", launch, 1);
    chk(launch_pc == 24'h012340, "R7 entry", launch_pc, 24'h012340);
    chk(launch_sp == 24'h04A000, "R7 stack", launch_sp, 24'h04A000);
    @(negedge clk);
    chk(launch == 1'b0, "R7 launch one cycle", launch, 0);
    chk(halted == 1'b0, "R7 not halted", halted, 0);

    // R5 load error
    do_reset();
    rx_byte(8'h28, 1'b0);
    expect_tx(8'h28, "R2 echo", 0);
    repeat (3) @(negedge clk);
    hex_err = 1'b1;
    @(negedge clk);
    hex_err = 1'b0;
    chk(halted == 1'b1, "R5 halted", halted, 1);
    expect_quiet(20, "R5 silent");

    // R8 wrong start byte, then R9 sticky halt
    do_reset();
    good_rate_and_load(24'h000100, 16'h1234);
    rx_byte(8'hC1, 1'b0);
    expect_tx(8'h62, "R8 error 1", -1);
    chk(halted == 1'b0, "R8 not yet halted", halted, 0);
    expect_tx(8'h62, "R8 error 2", -1);
    expect_tx(8'h62, "R8 error 3", -1);
    chk(halted == 1'b1, "R8 halted", halted, 1);
    rx_byte(8'hC0, 1'b0);
    hex_end = 1'b1; @(negedge clk); hex_end = 1'b0;
    rx_byte(8'h28, 1'b0);
    expect_quiet(20, "R9 halted ignores inputs");
    chk(halted == 1'b1, "R9 halt sticky", halted, 1);

    // R8 correct byte with a receive error
    do_reset();
    good_rate_and_load(24'h000200, 16'h00FF);
    rx_byte(8'hC0, 1'b1);
    expect_tx(8'h62, "R8 rx_err 1", -1);
    expect_tx(8'h62, "R8 rx_err 2", -1);
    expect_tx(8'h62, "R8 rx_err 3", -1);
    chk(halted == 1'b1, "R8 rx_err halted", halted, 1);
    expect_quiet(15, "R8 no launch");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule